// File: doc/BRIEF.md
# Permutation-Encoded Recency Tracker

This block holds the replacement state for one set of an N-way set-associative cache, with N equal to 4 or 8. Cached data never moves between ways. The block keeps a packed permutation of way indices instead. The first slot of the permutation names the most recently touched way and the last slot names the least recently touched way. Each slot is log2(N) bits wide, so the whole permutation is 8 bits for 4 ways and 24 bits for 8 ways.

A hit strobe with its way index, or a fill request, rewrites the permutation so that the touched way moves to the front. The entries that were ahead of it each move back one slot, and the entries behind it keep their slots. For a fill the block itself names the way to overwrite, which is the least recent way. The cache writes its new line into that way in the same cycle as the request, and the tracker then marks that way as most recent. Tag comparison and the data arrays belong to the surrounding cache.

Top module: `rank_order_tracker`

## Requirements
- R1: The parameter `NUM_WAYS` (4 or 8) sets the slot width W = log2(NUM_WAYS). `orderVec` is NUM_WAYS*W bits wide, and slot k sits at bits [k*W +: W]. Slot 0 is the most recent way and slot NUM_WAYS-1 is the least recent way.
- R2: While `rstN` is low, and at the first clock after it rises, slot k holds way index k (identity order, way 0 at the front).
- R3: A cycle with `hitValid` high moves `hitWay` into slot 0 at the next clock edge. The slots that held more recent ways each move back by one. The slots behind the old position of the hit way keep their values.
- R4: `victimWay` always equals the contents of the last slot (NUM_WAYS-1), and it changes with no clock delay.
- R5: A cycle with `fillReq` high and `hitValid` low moves the way shown on `victimWay` in that cycle into slot 0 at the next edge. Every other way moves back one slot.
- R6: When `hitValid` and `fillReq` are both high in the same cycle, only the hit way is moved to the front. The fill request has no further effect on the order.
- R7: A cycle with `hitValid` and `fillReq` both low leaves `orderVec` unchanged.
- R8: `orderVec` always holds every way index from 0 to NUM_WAYS-1 exactly once.
- R9: A hit on the way already in slot 0 leaves `orderVec` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hitValid | input | 1 | A lookup hit in this set during this cycle |
| hitWay | input | log2(NUM_WAYS) | Way index of the hit |
| fillReq | input | 1 | A line is being allocated into this set during this cycle |
| victimWay | output | log2(NUM_WAYS) | Way to overwrite, which is the least recent way |
| orderVec | output | NUM_WAYS*log2(NUM_WAYS) | Packed recency permutation; slot 0 is the most recent way |

## Verification
The hardest situation to reach from the ports is a hit on a way that sits deep in the order, while the ways behind it stay in place. The order has to be scrambled first. The stimulus does this with a chosen sequence of hits and fills, which puts each way at a known position before it hits the middle, last and front slots in turn. A long pseudo-random mix of hits, fills, simultaneous hit-and-fill and idle cycles then compares every update with a reference order kept in the bench. It also confirms after every step that the order is still a permutation.

// File: rtl/rt_pkg.sv
package rt_pkg;

  // Strobes the control stage sends to the permutation datapath.
  typedef struct packed {
    logic promote;  // rewrite the order this cycle
    logic useHit;   // the touched way comes from the hit index, else from the victim slot
  } strobe_t;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl (
  input  logic            hitValid,
  input  logic            fillReq,
  output rt_pkg::strobe_t strb
);

  // A hit takes priority over a fill in the same cycle.
  always_comb begin
    strb.promote = hitValid | fillReq;
    strb.useHit  = hitValid;
  end

endmodule

// File: rtl/rt_locate.sv
module rt_locate #(
  parameter int NUM_WAYS = 4,
  localparam int W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS*W-1:0] orderIn,
  input  logic [W-1:0]          target,
  output logic [NUM_WAYS-1:0]   atOrBehind  // bit i set when the target sits in slot i or a later slot
);

  logic [NUM_WAYS-1:0] matchVec;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_match
    assign matchVec[i] = (orderIn[i*W +: W] == target);
  end

  // Running OR from the tail towards the front.
  assign atOrBehind[NUM_WAYS-1] = matchVec[NUM_WAYS-1];
  for (genvar i = NUM_WAYS-2; i >= 0; i--) begin : g_scan
    assign atOrBehind[i] = matchVec[i] | atOrBehind[i+1];
  end

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath #(
  parameter int NUM_WAYS = 4,
  localparam int W = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rt_pkg::strobe_t       strb,
  input  logic [W-1:0]          hitWay,
  output logic [W-1:0]          victimWay,
  output logic [NUM_WAYS*W-1:0] orderVec
);

  logic [NUM_WAYS*W-1:0] orderQ;
  logic [NUM_WAYS*W-1:0] orderD;
  logic [W-1:0]          touched;
  logic [NUM_WAYS-1:0]   shiftSel;

  assign victimWay = orderQ[(NUM_WAYS-1)*W +: W];
  assign touched   = strb.useHit ? hitWay : victimWay;

  rt_locate #(.NUM_WAYS(NUM_WAYS)) locate_i (
    .orderIn    (orderQ),
    .target     (touched),
    .atOrBehind (shiftSel)
  );

  assign orderD[W-1:0] = strb.promote ? touched : orderQ[W-1:0];

  // Slot i takes slot i-1 when the touched way was at slot i or further back.
  for (genvar i = 1; i < NUM_WAYS; i++) begin : g_slot
    assign orderD[i*W +: W] = (strb.promote && shiftSel[i]) ? orderQ[(i-1)*W +: W]
                                                             : orderQ[i*W +: W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_WAYS; k++) orderQ[k*W +: W] <= W'(k);
    end else begin
      orderQ <= orderD;
    end
  end

  assign orderVec = orderQ;

endmodule

// File: rtl/rank_order_tracker.sv
module rank_order_tracker #(
  parameter int NUM_WAYS = 4,
  localparam int W = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hitValid,
  input  logic [W-1:0]          hitWay,
  input  logic                  fillReq,
  output logic [W-1:0]          victimWay,
  output logic [NUM_WAYS*W-1:0] orderVec
);

  rt_pkg::strobe_t strb;

  rt_ctrl ctrl_i (
    .hitValid (hitValid),
    .fillReq  (fillReq),
    .strb     (strb)
  );

  rt_datapath #(.NUM_WAYS(NUM_WAYS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hitWay    (hitWay),
    .victimWay (victimWay),
    .orderVec  (orderVec)
  );

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int NUM_WAYS = 4,
  localparam int W = $clog2(NUM_WAYS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  hitValid,
  input logic [W-1:0]          hitWay,
  input logic                  fillReq,
  input logic [W-1:0]          victimWay,
  input logic [NUM_WAYS*W-1:0] orderVec
);

  logic [NUM_WAYS*W-1:0] identOrder;
  logic [NUM_WAYS-1:0]   seenMask;

  always_comb begin
    for (int k = 0; k < NUM_WAYS; k++) identOrder[k*W +: W] = W'(k);
  end

  always_comb begin
    seenMask = '0;
    for (int k = 0; k < NUM_WAYS; k++) seenMask[orderVec[k*W +: W]] = 1'b1;
  end

  // R2: identity order right after reset
  a_r2_reset_identity: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> orderVec == identOrder);

  // R8: every way index present exactly once
  a_r8_permutation: assert property (@(posedge clk) disable iff (!rstN)
    seenMask == {NUM_WAYS{1'b1}});

  // R3 / R6: the hit way reaches the front
  a_r3_hit_front: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |=> orderVec[W-1:0] == $past(hitWay));

  // R5: the victim way reaches the front after a fill
  a_r5_fill_front: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !hitValid) |=> orderVec[W-1:0] == $past(victimWay));

  // R7: idle cycles hold the order
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!fillReq && !hitValid) |=> $stable(orderVec));

  // R9: a hit on the front way holds the order
  a_r9_front_hit_stable: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitWay == orderVec[W-1:0]) |=> $stable(orderVec));

endmodule

bind rank_order_tracker rt_checker #(.NUM_WAYS(NUM_WAYS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .hitValid  (hitValid),
  .hitWay    (hitWay),
  .fillReq   (fillReq),
  .victimWay (victimWay),
  .orderVec  (orderVec)
);

// File: tb/rank_order_tracker_tb_top.sv
`timescale 1ns/1ps
module rank_order_tracker_tb_top;

  localparam int N = 4;
  localparam int W = $clog2(N);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           hitValid = 1'b0;
  logic [W-1:0]   hitWay = '0;
  logic           fillReq = 1'b0;
  logic [W-1:0]   victimWay;
  logic [N*W-1:0] orderVec;

  int numChecks = 0;
  int numFails  = 0;
  int model [N];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  rank_order_tracker #(.NUM_WAYS(N)) dut_i (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .fillReq(fillReq), .victimWay(victimWay), .orderVec(orderVec)
  );

  function automatic logic [N*W-1:0] packModel();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(model[k]);
    return v;
  endfunction

  function automatic void promote(int w);
    int p = 0;
    for (int k = 0; k < N; k++) if (model[k] == w) p = k;
    for (int k = p; k > 0; k--) model[k] = model[k-1];
    model[0] = w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compares the order, the victim slot and permutation validity.
  task automatic checkState(input string req);
    logic [N-1:0] seen = '0;
    check(req, 32'(orderVec), 32'(packModel()));
    check("R4", 32'(victimWay), 32'(model[N-1]));
    for (int k = 0; k < N; k++) seen[orderVec[k*W +: W]] = 1'b1;
    check("R8", 32'(seen), 32'({N{1'b1}}));
  endtask

  // One clocked step; inputs driven at the falling edge and checked at the next one.
  task automatic step(input logic hv, input int hw, input logic fr, input string req);
    @(negedge clk);
    hitValid = hv; hitWay = W'(hw); fillReq = fr;
    #0.1;
    check("R4", 32'(victimWay), 32'(model[N-1]));
    if (hv) promote(hw);
    else if (fr) promote(model[N-1]);
    @(negedge clk);
    hitValid = 1'b0; fillReq = 1'b0;
    checkState(req);
  endtask

  task automatic t_reset();
    for (int k = 0; k < N; k++) model[k] = k;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkState("R2");
    check("R1", 32'(orderVec[W-1:0]), 32'd0);
    check("R1", 32'(orderVec[(N-1)*W +: W]), 32'(N-1));
    rstN = 1'b1;
    @(negedge clk);
    checkState("R2");
  endtask

  task automatic t_hits();
    step(1'b1, 2, 1'b0, "R3");      // middle slot
    step(1'b1, N-1, 1'b0, "R3");    // last slot
    step(1'b1, 1, 1'b0, "R3");
    step(1'b1, 0, 1'b0, "R3");
  endtask

  task automatic t_front_hit();
    step(1'b1, model[0], 1'b0, "R9");
    step(1'b1, model[0], 1'b0, "R9");
  endtask

  task automatic t_fills();
    step(1'b0, 0, 1'b1, "R5");
    step(1'b0, 0, 1'b1, "R5");
    step(1'b0, 0, 1'b1, "R5");
  endtask

  task automatic t_both();
    step(1'b1, model[1], 1'b1, "R6");
    step(1'b1, model[N-2], 1'b1, "R6");
  endtask

  task automatic t_idle();
    step(1'b0, 3, 1'b0, "R7");
    step(1'b0, 1, 1'b0, "R7");
  endtask

  task automatic t_mix();
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step(seed[20], int'(seed[24 +: W]), seed[27], "R3");
    end
  endtask

  initial begin
    #(200000 * 5);
    numFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

  initial begin
    t_reset();
    t_hits();
    t_front_hit();
    t_fills();
    t_both();
    t_idle();
    t_mix();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

endmodule